// File: doc/BRIEF.md
# Register-Driven I2C Transaction Engine

This block is an I2C bus master. Software describes one complete register-style transaction through a small register interface: the 7-bit target address, a register address of zero to three bytes, a payload of 1 to 16 bytes, the direction and the bus speed. Software then sets a go bit. The engine runs the whole transaction without further help. It sends the start condition, the address byte, the register-address bytes, a repeated start when the transfer is a read, the data bytes and the stop condition. It checks every acknowledge and aborts cleanly when the target refuses a byte.

Payload bytes move through an internal 16-byte buffer organised as four 32-bit words. Before a write, software fills the buffer. After a read, software collects the received bytes from it. The pins are open-drain enables: an enable at 1 pulls the line low, and an enable at 0 releases it. The engine never samples SCL, so a target that stretches the clock is not supported. A sticky fail flag reports a refused byte once the go bit has dropped.

Top module: `i2c_txn_engine`

## Requirements
- R1: After a synchronous reset, CTRL (index 0) and REGADDR (index 1) read as zero, and both `scl_oe` and `sda_oe` are 0 (lines released).
- R2: CTRL layout: bit 0 go/busy, bit 1 fail (read-only), bit 2 direction (1 = write, 0 = read), bits [5:4] register-address byte count (0..3), bits [9:8] speed, bits [19:16] payload length minus one, bits [30:24] 7-bit target address. REGADDR holds a 24-bit register address in bits [23:0]. Buffer word w is at index 4+w. A CTRL write with bit 0 clear stores the fields and reads them back unchanged.
- R3: Writing CTRL with bit 0 set while idle starts a transaction. Bit 0 then reads 1 until the engine finishes, and hardware clears it. While it is 1, every register write (CTRL, REGADDR, buffer) is ignored.
- R4: A write transaction is: start, address byte {addr,0}, the selected number of register-address bytes (most significant selected byte first, taken from REGADDR[8*n-1:0]), length+1 payload bytes, stop.
- R5: A read with a non-zero register-address count is: start, {addr,0}, the register-address bytes, repeated start, {addr,1}, length+1 received bytes, stop. With a count of zero it is a single start, {addr,1}, the received bytes and a stop.
- R6: Payload byte i, whether sent or received, sits in buffer word i/4, bits [8*(i%4)+7 : 8*(i%4)].
- R7: During reads the master acknowledges every received byte except the last, which it does not acknowledge.
- R8: If any address, register-address or write-payload byte is not acknowledged, the engine stops sending bytes, issues a stop condition, sets fail and clears busy.
- R9: Fail is cleared when a transaction is started. Fail changes only when a transaction completes, and it holds its value until the next start.
- R10: Speed value 1 selects a quarter-bit period of FAST_QTR clocks; any other value selects STD_QTR clocks. SCL is high for exactly two quarter periods in every bit.
- R11: SDA changes while SCL is high only to form a start, repeated start or stop condition. SCL is never sampled, so clock stretching has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 CTRL, 1 REGADDR, 4..7 buffer words) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the index presented on the previous clock |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Level of the SDA line |

## Verification
The bench shortens the quarter-bit periods to STD_QTR=8 and FAST_QTR=3 clocks and keeps the 16-byte buffer. With these values, the full 16-byte fast read and the three-byte register address both finish within a few thousand cycles. The SCL high time at each speed also becomes an exact, small number that can be compared directly. A behavioural target on the wired lines records every byte and acknowledge. It can refuse the address or any chosen byte, which exercises both abort paths and the fail flag across back-to-back transactions.

// File: rtl/i2c_txn_pkg.sv
package i2c_txn_pkg;
  localparam int DEV_W  = 7;
  localparam int REGA_W = 24;

  // CTRL field positions (also decoded by software)
  localparam int C_GO      = 0;
  localparam int C_FAIL    = 1;
  localparam int C_DIR     = 2;
  localparam int C_RW_LSB  = 4;
  localparam int C_SPD_LSB = 8;
  localparam int C_LEN_LSB = 16;
  localparam int C_DEV_LSB = 24;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_RSTART, S_BIT, S_STOP
  } seq_state_t;

  typedef enum logic [2:0] {
    G_DEVW, G_REG, G_DEVR, G_WDAT, G_RDAT
  } stage_t;
endpackage

// File: rtl/i2c_qtr_tick.sv
module i2c_qtr_tick #(
  parameter int STD_QTR  = 500,
  parameter int FAST_QTR = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAXQ = (STD_QTR > FAST_QTR) ? STD_QTR : FAST_QTR;
  localparam int CW   = $clog2(MAXQ + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = fast ? CW'(FAST_QTR - 1) : CW'(STD_QTR - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  generate
    if (STD_QTR > 1 && FAST_QTR > 1) begin : g_chk
      // quarter ticks are single-cycle strobes, spaced by the selected period
      assert_tick_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/i2c_word_buf.sv
module i2c_word_buf #(
  parameter int BYTES = 16
) (
  input  logic                            clk,
  input  logic                            we,
  input  logic [$clog2(BYTES/4)-1:0]      waddr,
  input  logic [3:0]                      be,
  input  logic [31:0]                     wdata,
  input  logic [$clog2(BYTES/4)-1:0]      raddr,
  output logic [31:0]                     rword,
  input  logic [$clog2(BYTES)-1:0]        byte_idx,
  output logic [7:0]                      rbyte
);
  localparam int WORDS = BYTES / 4;
  localparam int IW    = $clog2(BYTES);

  logic [31:0] mem [WORDS];
  logic [31:0] bword;

  // single write port with byte enables, so the array maps onto RAM
  always_ff @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      if (we && be[b]) mem[waddr][8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  assign rword = mem[raddr];
  assign bword = mem[byte_idx[IW-1:2]];
  assign rbyte = bword[{byte_idx[1:0], 3'b000} +: 8];
endmodule

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
  import i2c_txn_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  input  logic [DEV_W-1:0]  dev,
  input  logic [1:0]        regw,
  input  logic [REGA_W-1:0] rega,
  input  logic              dir_wr,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [7:0]        tx_byte,
  input  logic              sda_in,
  output logic [LEN_W-1:0]  byte_idx,
  output logic              rx_we,
  output logic [7:0]        rx_data,
  output logic              scl_lo,
  output logic              sda_lo,
  output logic              done,
  output logic              nack,
  output logic              active
);
  seq_state_t      state;
  stage_t          stage;
  logic [1:0]      q;
  logic [3:0]      bitn;
  logic [7:0]      sh;
  logic [1:0]      regk;
  logic [LEN_W-1:0] idx;
  logic            ack_bad;
  logic [1:0]      rsel;
  logic [7:0]      cur_byte;

  assign active   = (state != S_IDLE);
  assign byte_idx = idx;
  assign rsel     = regw - 2'd1 - regk;

  always_comb begin
    case (stage)
      G_DEVW:  cur_byte = {dev, 1'b0};
      G_DEVR:  cur_byte = {dev, 1'b1};
      G_REG:   cur_byte = rega[{rsel, 3'b000} +: 8];
      G_WDAT:  cur_byte = tx_byte;
      default: cur_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      stage   <= G_DEVW;
      q       <= '0;
      bitn    <= '0;
      sh      <= '0;
      regk    <= '0;
      idx     <= '0;
      ack_bad <= 1'b0;
      rx_data <= '0;
      rx_we   <= 1'b0;
      scl_lo  <= 1'b0;
      sda_lo  <= 1'b0;
      done    <= 1'b0;
      nack    <= 1'b0;
    end else begin
      done  <= 1'b0;
      rx_we <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          state <= S_START;
          q     <= '0;
          bitn  <= '0;
          regk  <= '0;
          idx   <= '0;
          nack  <= 1'b0;
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (state)
          S_START: begin
            case (q)
              2'd1: sda_lo <= 1'b1;
              2'd2: scl_lo <= 1'b1;
              2'd3: begin
                state <= S_BIT;
                bitn  <= '0;
                stage <= (dir_wr || regw != 2'd0) ? G_DEVW : G_DEVR;
              end
              default: ;
            endcase
          end
          S_RSTART: begin
            case (q)
              2'd0: sda_lo <= 1'b0;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b1;
              default: begin
                scl_lo <= 1'b1;
                state  <= S_BIT;
                bitn   <= '0;
                stage  <= G_DEVR;
              end
            endcase
          end
          S_STOP: begin
            case (q)
              2'd0: sda_lo <= 1'b1;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b0;
              default: begin
                state <= S_IDLE;
                done  <= 1'b1;
              end
            endcase
          end
          S_BIT: begin
            case (q)
              2'd0: begin
                if (bitn == 4'd0) begin
                  sda_lo <= !cur_byte[7];
                  sh     <= {cur_byte[6:0], 1'b0};
                end else if (bitn < 4'd8) begin
                  sda_lo <= !sh[7];
                  sh     <= {sh[6:0], 1'b0};
                end else begin
                  // acknowledge slot: master acks received bytes but the last
                  sda_lo <= (stage == G_RDAT) && (idx != len_m1);
                end
              end
              2'd1: scl_lo <= 1'b0;
              2'd2: begin
                if (bitn < 4'd8) rx_data <= {rx_data[6:0], sda_in};
                else             ack_bad <= sda_in;
              end
              default: begin
                scl_lo <= 1'b1;
                if (bitn < 4'd8) begin
                  bitn <= bitn + 4'd1;
                  if (stage == G_RDAT && bitn == 4'd7) rx_we <= 1'b1;
                end else begin
                  bitn <= '0;
                  if (stage != G_RDAT && ack_bad) begin
                    nack  <= 1'b1;
                    state <= S_STOP;
                  end else begin
                    case (stage)
                      G_DEVW: begin
                        if (regw != 2'd0) begin
                          stage <= G_REG;
                          regk  <= '0;
                        end else begin
                          stage <= G_WDAT;
                          idx   <= '0;
                        end
                      end
                      G_REG: begin
                        if (regk == regw - 2'd1) begin
                          if (dir_wr) begin
                            stage <= G_WDAT;
                            idx   <= '0;
                          end else begin
                            state <= S_RSTART;
                          end
                        end else begin
                          regk <= regk + 2'd1;
                        end
                      end
                      G_DEVR: begin
                        stage <= G_RDAT;
                        idx   <= '0;
                      end
                      default: begin
                        if (idx == len_m1) state <= S_STOP;
                        else               idx   <= idx + 1'b1;
                      end
                    endcase
                  end
                end
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  // SDA moves under a high SCL only inside start, repeated-start and stop
  assert_sda_under_scl_R11: assert property (@(posedge clk) disable iff (rst)
    (sda_lo != $past(sda_lo)) && !$past(scl_lo) && !scl_lo
      |-> ($past(state) == S_START || $past(state) == S_RSTART || $past(state) == S_STOP));

  // a refused byte that the master sent leads straight to the stop condition
  assert_nack_to_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_BIT && tick && q == 2'd3 && bitn == 4'd8 && stage != G_RDAT && ack_bad)
      |=> (state == S_STOP));
endmodule

// File: rtl/i2c_txn_engine.sv
module i2c_txn_engine
  import i2c_txn_pkg::*;
#(
  parameter int STD_QTR   = 500,
  parameter int FAST_QTR  = 125,
  parameter int BUF_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int WA_W  = $clog2(WORDS);
  localparam int LEN_W = $clog2(BUF_BYTES);

  logic [DEV_W-1:0]  dev_r;
  logic [1:0]        regw_r;
  logic [1:0]        spd_r;
  logic [LEN_W-1:0]  len_r;
  logic              dir_r;
  logic [REGA_W-1:0] rega_r;
  logic              busy_r;
  logic              fail_r;
  logic              go_pulse;

  logic              tick;
  logic              seq_active;
  logic              seq_done;
  logic              seq_nack;
  logic              rx_we;
  logic [7:0]        rx_data;
  logic [LEN_W-1:0]  eng_idx;
  logic [7:0]        eng_byte;
  logic [31:0]       sw_word;

  logic              bw_we;
  logic [WA_W-1:0]   bw_addr;
  logic [3:0]        bw_be;
  logic [31:0]       bw_data;
  logic              sw_buf_we;
  logic [31:0]       ctrl_rd;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata;
  assign sw_buf_we    = reg_we && !busy_r && reg_addr[2];

  // register file: all writes are ignored while a transaction runs
  always_ff @(posedge clk) begin
    if (rst) begin
      dev_r    <= '0;
      regw_r   <= '0;
      spd_r    <= '0;
      len_r    <= '0;
      dir_r    <= 1'b0;
      rega_r   <= '0;
      busy_r   <= 1'b0;
      fail_r   <= 1'b0;
      go_pulse <= 1'b0;
    end else begin
      go_pulse <= 1'b0;
      if (busy_r) begin
        if (seq_done) begin
          busy_r <= 1'b0;
          fail_r <= seq_nack;
        end
      end else if (reg_we) begin
        if (reg_addr == 3'd0) begin
          dev_r  <= reg_wdata[C_DEV_LSB +: DEV_W];
          regw_r <= reg_wdata[C_RW_LSB +: 2];
          spd_r  <= reg_wdata[C_SPD_LSB +: 2];
          len_r  <= reg_wdata[C_LEN_LSB +: LEN_W];
          dir_r  <= reg_wdata[C_DIR];
          if (reg_wdata[C_GO]) begin
            busy_r   <= 1'b1;
            fail_r   <= 1'b0;
            go_pulse <= 1'b1;
          end
        end else if (reg_addr == 3'd1) begin
          rega_r <= reg_wdata[REGA_W-1:0];
        end
      end
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[C_GO]                  = busy_r;
    ctrl_rd[C_FAIL]                = fail_r;
    ctrl_rd[C_DIR]                 = dir_r;
    ctrl_rd[C_RW_LSB +: 2]         = regw_r;
    ctrl_rd[C_SPD_LSB +: 2]        = spd_r;
    ctrl_rd[C_LEN_LSB +: LEN_W]    = len_r;
    ctrl_rd[C_DEV_LSB +: DEV_W]    = dev_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_addr[2]) begin
      reg_rdata <= sw_word;
    end else if (reg_addr == 3'd0) begin
      reg_rdata <= ctrl_rd;
    end else if (reg_addr == 3'd1) begin
      reg_rdata <= {{(32-REGA_W){1'b0}}, rega_r};
    end else begin
      reg_rdata <= '0;
    end
  end

  // buffer write port: engine owns it while busy, software while idle
  always_comb begin
    if (rx_we) begin
      bw_we   = 1'b1;
      bw_addr = eng_idx[LEN_W-1:2];
      bw_be   = 4'b0001 << eng_idx[1:0];
      bw_data = {4{rx_data}};
    end else begin
      bw_we   = sw_buf_we;
      bw_addr = reg_addr[WA_W-1:0];
      bw_be   = 4'b1111;
      bw_data = reg_wdata;
    end
  end

  i2c_word_buf #(.BYTES(BUF_BYTES)) i_buf (
    .clk      (clk),
    .we       (bw_we),
    .waddr    (bw_addr),
    .be       (bw_be),
    .wdata    (bw_data),
    .raddr    (reg_addr[WA_W-1:0]),
    .rword    (sw_word),
    .byte_idx (eng_idx),
    .rbyte    (eng_byte)
  );

  i2c_qtr_tick #(.STD_QTR(STD_QTR), .FAST_QTR(FAST_QTR)) i_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (seq_active),
    .fast (spd_r == 2'd1),
    .tick (tick)
  );

  i2c_bit_seq #(.LEN_W(LEN_W)) i_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (go_pulse),
    .tick     (tick),
    .dev      (dev_r),
    .regw     (regw_r),
    .rega     (rega_r),
    .dir_wr   (dir_r),
    .len_m1   (len_r),
    .tx_byte  (eng_byte),
    .sda_in   (sda_in),
    .byte_idx (eng_idx),
    .rx_we    (rx_we),
    .rx_data  (rx_data),
    .scl_lo   (scl_oe),
    .sda_lo   (sda_oe),
    .done     (seq_done),
    .nack     (seq_nack),
    .active   (seq_active)
  );

  // busy holds from the go write until the sequencer reports completion
  assert_busy_holds_R3: assert property (@(posedge clk) disable iff (rst)
    busy_r && !seq_done |=> busy_r);

  // fail only rises as a transaction completes
  assert_fail_at_done_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_r) |-> $past(seq_done));

  // received bytes are stored only during a running transaction
  assert_rx_store_busy_R6: assert property (@(posedge clk) disable iff (rst)
    rx_we |-> busy_r);
endmodule

// File: tb/test_i2c_txn_engine.sv
`timescale 1ns/1ps
module test_i2c_txn_engine;
  localparam int STD_Q  = 8;
  localparam int FAST_Q = 3;
  localparam logic [6:0] SLV = 7'h50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        scl_oe, sda_oe, sda_in;
  logic        s_drv = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_in = ~(sda_oe | s_drv);

  i2c_txn_engine #(.STD_QTR(STD_Q), .FAST_QTR(FAST_Q), .BUF_BYTES(16)) i_i2c_txn_engine (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural target on the wired lines ----------------
  int starts = 0, stops = 0, viol = 0, hi_cnt = 0, last_hi = 0;
  logic [7:0] seen[$];
  bit         mack[$];
  int         nack_at = -1;
  int         rd_base = 0;
  bit         p_scl = 1, p_sda = 1, act_s = 0, ign = 0, rdph = 0, lastack = 0, ackbit = 0;
  int         bc = 0, fb = 0, k = 0;
  logic [7:0] sh = '0, tx = '0;

  function automatic logic [7:0] smem(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  always @(negedge clk) begin
    bit scl_l, sda_l;
    scl_l = ~scl_oe;
    sda_l = sda_in;
    if (!rst) begin
      if (scl_l) hi_cnt++;
      if (p_scl && scl_l && p_sda && !sda_l) begin
        starts++; act_s = 1; ign = 0; rdph = 0; bc = 0; fb = 0; k = 0; s_drv = 0;
      end else if (p_scl && scl_l && !p_sda && sda_l) begin
        stops++; act_s = 0; s_drv = 0;
      end else if (p_scl && scl_l && (p_sda != sda_l) && act_s && bc != 0) begin
        viol++;
      end else if (act_s && !ign) begin
        if (!p_scl && scl_l) begin
          if (bc < 8) sh = {sh[6:0], sda_l};
          else        ackbit = sda_l;
          bc++;
        end else if (p_scl && !scl_l) begin
          if (bc == 8) begin
            if (!rdph) begin
              seen.push_back(sh);
              lastack = (fb == 0) ? (sh[7:1] == SLV) : (fb != nack_at);
              s_drv = lastack;
            end else begin
              s_drv = 0;
            end
          end else if (bc == 9) begin
            bc = 0;
            if (!rdph) begin
              if (!lastack) begin
                ign = 1; s_drv = 0;
              end else if (fb == 0 && seen[$][0]) begin
                rdph = 1; tx = smem(rd_base + k); s_drv = ~tx[7];
              end else begin
                s_drv = 0;
              end
              fb++;
            end else begin
              mack.push_back(ackbit);
              k++;
              if (!ackbit) begin
                tx = smem(rd_base + k); s_drv = ~tx[7];
              end else begin
                s_drv = 0; ign = 1;
              end
            end
          end else if (rdph && bc >= 1 && bc <= 7) begin
            s_drv = ~tx[7 - bc];
          end
        end
      end
      if (p_scl && !scl_l) begin
        last_hi = hi_cnt;
        hi_cnt  = 0;
      end
      p_scl = scl_l;
      p_sda = sda_l;
    end
  end

  // ---------------- register access ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(input logic [6:0] dev, input logic [1:0] rw,
                                     input logic [1:0] spd, input logic [3:0] lm1, input bit wrd);
    return (32'(dev) << 24) | (32'(lm1) << 16) | (32'(spd) << 8) | (32'(rw) << 4) | (32'(wrd) << 2);
  endfunction

  task automatic wait_done(output logic [31:0] v);
    v = 32'h1;
    for (int i = 0; i < 20000 && v[0]; i++) rd(3'd0, v);
  endtask

  task automatic clear_mon();
    seen.delete(); mack.delete(); starts = 0; stops = 0;
  endtask

  logic [7:0] exp_q[$];

  task automatic cmp_seen(input string tag);
    bit ok = (seen.size() == exp_q.size());
    check(ok, {tag, " byte count"}, 32'(seen.size()), 32'(exp_q.size()));
    if (ok) begin
      for (int i = 0; i < exp_q.size(); i++)
        check(seen[i] == exp_q[i], {tag, " bus byte"}, 32'(seen[i]), 32'(exp_q[i]));
    end
  endtask

  task automatic cmp_read_words(input string tag, input int base, input int n);
    logic [31:0] v;
    for (int w = 0; w < (n + 3) / 4; w++) begin
      rd(3'(4 + w), v);
      for (int b = 0; b < 4; b++) begin
        if (w * 4 + b < n)
          check(v[8*b +: 8] == smem(base + w * 4 + b), tag, 32'(v[8*b +: 8]), 32'(smem(base + w * 4 + b)));
      end
    end
  endtask

  task automatic cmp_mack(input string tag, input int n);
    check(mack.size() == n, {tag, " ack count"}, 32'(mack.size()), 32'(n));
    for (int i = 0; i < mack.size(); i++)
      check(mack[i] == (i == n - 1), tag, 32'(mack[i]), 32'(i == n - 1));
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, v); check(v == 0, "R1 CTRL after reset", v, 0);
    rd(3'd1, v); check(v == 0, "R1 REGADDR after reset", v, 0);
    check(scl_oe == 0 && sda_oe == 0, "R1 lines released", {30'd0, scl_oe, sda_oe}, 0);

    // R2 field readback without go
    wr(3'd0, mk(7'h2A, 2'd2, 2'd1, 4'd9, 1));
    rd(3'd0, v); check(v == mk(7'h2A, 2'd2, 2'd1, 4'd9, 1), "R2 CTRL readback", v, mk(7'h2A, 2'd2, 2'd1, 4'd9, 1));

    // R4 R6 R10 write, two register bytes, five payload bytes, standard speed
    clear_mon();
    wr(3'd1, 32'h00AB1234);
    wr(3'd4, 32'h44332211);
    wr(3'd5, 32'h00000055);
    wr(3'd0, mk(SLV, 2'd2, 2'd0, 4'd4, 1) | 32'h1);
    rd(3'd0, v); check(v[0] == 1'b1, "R3 busy after go", v, 32'h1);
    // R3 writes during busy are ignored
    wr(3'd1, 32'h00FFFFFF);
    wr(3'd0, mk(7'h11, 2'd1, 2'd1, 4'd1, 0) | 32'h1);
    wr(3'd5, 32'hDEADBEEF);
    wait_done(v);
    check(v == mk(SLV, 2'd2, 2'd0, 4'd4, 1), "R3 CTRL unchanged, busy cleared", v, mk(SLV, 2'd2, 2'd0, 4'd4, 1));
    rd(3'd1, v); check(v == 32'h00AB1234, "R3 REGADDR unchanged", v, 32'h00AB1234);
    rd(3'd5, v); check(v == 32'h00000055, "R3 buffer unchanged", v, 32'h55);
    exp_q = '{8'hA0, 8'h12, 8'h34, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    cmp_seen("R4 R6 write sequence");
    check(starts == 1 && stops == 1, "R4 one start one stop", 32'(starts*16+stops), 32'h11);
    check(last_hi == 2 * STD_Q, "R10 standard SCL high", 32'(last_hi), 32'(2*STD_Q));

    // R5 R6 R7 random read, one register byte, six bytes
    clear_mon(); rd_base = 16;
    wr(3'd1, 32'h00000077);
    wr(3'd0, mk(SLV, 2'd1, 2'd0, 4'd5, 0) | 32'h1);
    wait_done(v);
    check(v[1] == 1'b0, "R5 read no fail", v, 0);
    exp_q = '{8'hA0, 8'h77, 8'hA1};
    cmp_seen("R5 random read");
    check(starts == 2 && stops == 1, "R5 repeated start", 32'(starts*16+stops), 32'h21);
    cmp_read_words("R6 read layout", 16, 6);
    cmp_mack("R7 master ack", 6);

    // R5 read with no register bytes, one byte
    clear_mon(); rd_base = 200;
    wr(3'd0, mk(SLV, 2'd0, 2'd0, 4'd0, 0) | 32'h1);
    wait_done(v);
    exp_q = '{8'hA1};
    cmp_seen("R5 direct read");
    check(starts == 1 && stops == 1, "R5 single start", 32'(starts*16+stops), 32'h11);
    cmp_read_words("R6 single byte", 200, 1);
    cmp_mack("R7 single nack", 1);

    // R10 fast 16-byte read, three register bytes
    clear_mon(); rd_base = 64;
    wr(3'd1, 32'h000A0B0C);
    wr(3'd0, mk(SLV, 2'd3, 2'd1, 4'd15, 0) | 32'h1);
    wait_done(v);
    exp_q = '{8'hA0, 8'h0A, 8'h0B, 8'h0C, 8'hA1};
    cmp_seen("R5 three register bytes");
    check(last_hi == 2 * FAST_Q, "R10 fast SCL high", 32'(last_hi), 32'(2*FAST_Q));
    cmp_read_words("R6 full buffer", 64, 16);
    cmp_mack("R7 sixteen bytes", 16);

    // R8 address refused
    clear_mon();
    wr(3'd0, mk(7'h33, 2'd1, 2'd0, 4'd3, 1) | 32'h1);
    wait_done(v);
    check(v[1] == 1'b1 && v[0] == 1'b0, "R8 fail on address nack", v, 32'h2);
    exp_q = '{8'h66};
    cmp_seen("R8 address abort");
    check(stops == 1, "R8 stop after nack", 32'(stops), 1);

    // R9 fail sticky, then cleared by the next start
    repeat (40) @(negedge clk);
    rd(3'd0, v); check(v[1] == 1'b1, "R9 fail sticky", v, 32'h2);
    clear_mon(); rd_base = 5;
    wr(3'd0, mk(SLV, 2'd0, 2'd0, 4'd1, 0) | 32'h1);
    rd(3'd0, v); check(v[1] == 1'b0, "R9 fail cleared at start", v, 32'h1);
    wait_done(v);
    check(v[1] == 1'b0, "R9 success keeps fail clear", v, 0);

    // R8 payload byte refused
    clear_mon(); nack_at = 3;
    wr(3'd1, 32'h00000005);
    wr(3'd0, mk(SLV, 2'd1, 2'd0, 4'd7, 1) | 32'h1);
    wait_done(v);
    nack_at = -1;
    check(v[1] == 1'b1, "R8 fail on data nack", v, 32'h2);
    exp_q = '{8'hA0, 8'h05, smem(5), smem(6)};
    cmp_seen("R8 data abort");

    // R11 SDA only moved under high SCL for start and stop
    check(viol == 0, "R11 SDA stable while SCL high", 32'(viol), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule